// File: doc/BRIEF.md
# Dual-Core Lockstep Comparator with Recovery Snapshot

This block sits beside two identical processor cores running in lockstep and compares three groups of their signals every cycle. The groups are the register-file write port, a register-content word each core exposes, and the prefetched instruction word. A difference in any group sets its own sticky flag. While any flag is set, an interrupt request is held high, so that recovery can run under software control.

While both cores agree, a snapshot of the primary core's last good state is kept in hardware. This state is the last committed PC and the last register write (index and value). The first mismatch freezes the snapshot, and it stays frozen until software has cleared every flag. The interrupt handler reads the flags and the snapshot over an APB slave port to rebuild the core's state.

After reset, the comparison is masked for a programmable number of cycles so that both cores can initialise. Software can re-arm that mask window through APB.

Top module: `lockstep_chk`

## Requirements
- R1: Write group (status bit 0): when either core's write enable is high, a difference in write enable, destination index or write value sets the flag on the next clock edge. When both enables are low, the index and value are ignored.
- R2: Register-content group (status bit 1): any difference between the two cores' register-content words sets the flag on the next clock edge.
- R3: Fetch group (status bit 2): when either core's fetch-valid is high, a difference in fetch-valid or instruction word sets the flag. When both fetch-valids are low, the words are ignored.
- R4: Flags are sticky. A write to address 0x00 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged. A new mismatch in the same cycle wins over the clear.
- R5: irq_o is high whenever any flag is set. It goes low in the cycle after the write that clears the last flag.
- R6: While no flag is set and no mismatch is seen, the snapshot follows the primary core. Address 0x08 returns the last committed PC, 0x0C returns the last write index in bits 4:0, and 0x10 returns the last write value.
- R7: The snapshot is not updated in the cycle a mismatch is detected. It then stays frozen until all flags are clear.
- R8: For MASK_CYCLES clock edges after reset is released, mismatches are ignored. A write to 0x04 reloads this mask counter, and a read of 0x04 returns the remaining count.
- R9: The APB port has zero wait states, PSLVERR is always low, reads have no side effects, and a read from any address other than 0x00 to 0x10 returns zero.
- R10: After reset, the flags, irq_o and all snapshot registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_wr_en_i | input | 1 | Primary core register write enable |
| a_wr_idx_i | input | IDX_W | Primary core write index |
| a_wr_data_i | input | DATA_W | Primary core write value |
| b_wr_en_i | input | 1 | Shadow core register write enable |
| b_wr_idx_i | input | IDX_W | Shadow core write index |
| b_wr_data_i | input | DATA_W | Shadow core write value |
| a_rf_val_i | input | DATA_W | Primary core register-content word |
| b_rf_val_i | input | DATA_W | Shadow core register-content word |
| a_fetch_vld_i | input | 1 | Primary core prefetch valid |
| a_fetch_i | input | DATA_W | Primary core prefetched word |
| b_fetch_vld_i | input | 1 | Shadow core prefetch valid |
| b_fetch_i | input | DATA_W | Shadow core prefetched word |
| a_commit_i | input | 1 | Primary core commits an instruction |
| a_pc_i | input | DATA_W | Primary core committed PC |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable |
| pwrite_i | input | 1 | APB write |
| paddr_i | input | 8 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, always high |
| pslverr_o | output | 1 | APB error, always low |
| err_flags_o | output | 3 | Sticky flags {fetch, rf, write} |
| irq_o | output | 1 | Recovery interrupt request |

## Verification
The hardest situation to reach is the boundary between tracking and freezing. In it, a mismatch arrives in the same cycle as a commit, and later commits keep arriving while the flags are still set. The snapshot must hold the state from before the faulty cycle.

The stimulus produces this directly by pairing a fetch mismatch with a new PC. It also gets there at random, by corrupting one field in one group while commits and writes continue. It then reads the snapshot back over APB before and after clearing the flags. The mask window is probed at both ends: mismatches are driven up to the last masked edge and on the first edge after it, both after reset and after a software reload.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;
  localparam int unsigned NGRP   = 3;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned BUS_W  = 32;

  typedef enum int unsigned {GRP_WR = 0, GRP_RF = 1, GRP_FETCH = 2} grp_e;

  localparam logic [ADDR_W-1:0] A_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] A_MASK   = 8'h04;
  localparam logic [ADDR_W-1:0] A_PC     = 8'h08;
  localparam logic [ADDR_W-1:0] A_IDX    = 8'h0C;
  localparam logic [ADDR_W-1:0] A_DATA   = 8'h10;
endpackage

// File: rtl/lockstep_cmp.sv
module lockstep_cmp import lockstep_pkg::*; #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned MASK_W      = 8,
  parameter int unsigned MASK_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_wr_en_i,
  input  logic [IDX_W-1:0]  a_wr_idx_i,
  input  logic [DATA_W-1:0] a_wr_data_i,
  input  logic              b_wr_en_i,
  input  logic [IDX_W-1:0]  b_wr_idx_i,
  input  logic [DATA_W-1:0] b_wr_data_i,
  input  logic [DATA_W-1:0] a_rf_val_i,
  input  logic [DATA_W-1:0] b_rf_val_i,
  input  logic              a_fetch_vld_i,
  input  logic [DATA_W-1:0] a_fetch_i,
  input  logic              b_fetch_vld_i,
  input  logic [DATA_W-1:0] b_fetch_i,
  input  logic              mask_ld_i,
  input  logic [MASK_W-1:0] mask_val_i,
  output logic [NGRP-1:0]   mis_o,
  output logic [MASK_W-1:0] mask_cnt_o
);
  localparam logic [MASK_W-1:0] MASK_RST = MASK_W'(MASK_CYCLES);

  logic [NGRP-1:0]   raw;
  logic [MASK_W-1:0] cnt_q;
  logic              masked;

  assign masked = (cnt_q != '0);

  always_comb begin
    raw            = '0;
    raw[GRP_WR]    = (a_wr_en_i | b_wr_en_i) &&
                     ({a_wr_en_i, a_wr_idx_i, a_wr_data_i} != {b_wr_en_i, b_wr_idx_i, b_wr_data_i});
    raw[GRP_RF]    = (a_rf_val_i != b_rf_val_i);
    raw[GRP_FETCH] = (a_fetch_vld_i | b_fetch_vld_i) &&
                     ({a_fetch_vld_i, a_fetch_i} != {b_fetch_vld_i, b_fetch_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= MASK_RST;
    else if (mask_ld_i) cnt_q <= mask_val_i;
    else if (masked)    cnt_q <= cnt_q - 1'b1;
  end

  assign mis_o      = masked ? '0 : raw;
  assign mask_cnt_o = cnt_q;
endmodule

// File: rtl/lockstep_snap.sv
module lockstep_snap #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] pc_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o   <= '0;
      idx_o  <= '0;
      data_o <= '0;
    end else if (upd_i) begin
      if (commit_i) pc_o <= pc_i;
      if (wr_en_i) begin
        idx_o  <= wr_idx_i;
        data_o <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/lockstep_apb.sv
module lockstep_apb import lockstep_pkg::*; #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned MASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [BUS_W-1:0]  pwdata_i,
  output logic [BUS_W-1:0]  prdata_o,
  input  logic [NGRP-1:0]   mis_i,
  input  logic [MASK_W-1:0] mask_cnt_i,
  input  logic [DATA_W-1:0] snap_pc_i,
  input  logic [IDX_W-1:0]  snap_idx_i,
  input  logic [DATA_W-1:0] snap_data_i,
  output logic [NGRP-1:0]   flags_o,
  output logic              mask_ld_o,
  output logic [MASK_W-1:0] mask_val_o
);
  logic            acc_wr;
  logic [NGRP-1:0] clr;

  assign acc_wr     = psel_i & penable_i & pwrite_i;
  assign clr        = (acc_wr && paddr_i == A_STATUS) ? pwdata_i[NGRP-1:0] : '0;
  assign mask_ld_o  = acc_wr && (paddr_i == A_MASK);
  assign mask_val_o = pwdata_i[MASK_W-1:0];

  for (genvar g = 0; g < NGRP; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_o[g] <= 1'b0;
      else         flags_o[g] <= (flags_o[g] & ~clr[g]) | mis_i[g];
    end
  end

  always_comb begin
    case (paddr_i)
      A_STATUS: prdata_o = BUS_W'(flags_o);
      A_MASK:   prdata_o = BUS_W'(mask_cnt_i);
      A_PC:     prdata_o = BUS_W'(snap_pc_i);
      A_IDX:    prdata_o = BUS_W'(snap_idx_i);
      A_DATA:   prdata_o = BUS_W'(snap_data_i);
      default:  prdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lockstep_chk.sv
module lockstep_chk import lockstep_pkg::*; #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned MASK_W      = 8,
  parameter int unsigned MASK_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_wr_en_i,
  input  logic [IDX_W-1:0]  a_wr_idx_i,
  input  logic [DATA_W-1:0] a_wr_data_i,
  input  logic              b_wr_en_i,
  input  logic [IDX_W-1:0]  b_wr_idx_i,
  input  logic [DATA_W-1:0] b_wr_data_i,
  input  logic [DATA_W-1:0] a_rf_val_i,
  input  logic [DATA_W-1:0] b_rf_val_i,
  input  logic              a_fetch_vld_i,
  input  logic [DATA_W-1:0] a_fetch_i,
  input  logic              b_fetch_vld_i,
  input  logic [DATA_W-1:0] b_fetch_i,
  input  logic              a_commit_i,
  input  logic [DATA_W-1:0] a_pc_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [7:0]        paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic [2:0]        err_flags_o,
  output logic              irq_o
);
  logic [NGRP-1:0]   mis;
  logic [MASK_W-1:0] mask_cnt;
  logic              mask_ld;
  logic [MASK_W-1:0] mask_val;
  logic [DATA_W-1:0] snap_pc;
  logic [IDX_W-1:0]  snap_idx;
  logic [DATA_W-1:0] snap_data;
  logic              snap_upd;

  lockstep_cmp #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .MASK_W(MASK_W), .MASK_CYCLES(MASK_CYCLES)
  ) u_cmp (
    .clk_i, .rst_ni,
    .a_wr_en_i, .a_wr_idx_i, .a_wr_data_i,
    .b_wr_en_i, .b_wr_idx_i, .b_wr_data_i,
    .a_rf_val_i, .b_rf_val_i,
    .a_fetch_vld_i, .a_fetch_i, .b_fetch_vld_i, .b_fetch_i,
    .mask_ld_i(mask_ld), .mask_val_i(mask_val),
    .mis_o(mis), .mask_cnt_o(mask_cnt)
  );

  // freeze from the faulty cycle until every flag is cleared
  assign snap_upd = ~|err_flags_o & ~|mis;

  lockstep_snap #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_snap (
    .clk_i, .rst_ni,
    .upd_i(snap_upd), .commit_i(a_commit_i), .pc_i(a_pc_i),
    .wr_en_i(a_wr_en_i), .wr_idx_i(a_wr_idx_i), .wr_data_i(a_wr_data_i),
    .pc_o(snap_pc), .idx_o(snap_idx), .data_o(snap_data)
  );

  lockstep_apb #(.DATA_W(DATA_W), .IDX_W(IDX_W), .MASK_W(MASK_W)) u_apb (
    .clk_i, .rst_ni,
    .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i, .prdata_o,
    .mis_i(mis), .mask_cnt_i(mask_cnt),
    .snap_pc_i(snap_pc), .snap_idx_i(snap_idx), .snap_data_i(snap_data),
    .flags_o(err_flags_o), .mask_ld_o(mask_ld), .mask_val_o(mask_val)
  );

  assign irq_o     = |err_flags_o;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
endmodule

// File: rtl/lockstep_chk_sva.sv
module lockstep_chk_sva #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MASK_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_wr_en_i,
  input logic              b_wr_en_i,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [7:0]        paddr_i,
  input logic [31:0]       pwdata_i,
  input logic [31:0]       prdata_o,
  input logic [2:0]        err_flags_o,
  input logic              irq_o,
  input logic [MASK_W-1:0] mask_cnt,
  input logic [DATA_W-1:0] snap_pc,
  input logic [DATA_W-1:0] snap_data
);
  logic clr_wr;
  assign clr_wr = psel_i && penable_i && pwrite_i && (paddr_i == 8'h00);

  // R1
  wr_en_diff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_en_i != b_wr_en_i && mask_cnt == '0) |=> err_flags_o[0]);

  // R4
  sticky_rf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flags_o[1] && !(clr_wr && pwdata_i[1])) |=> err_flags_o[1]);

  // R5
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(clr_wr));

  // R7
  snap_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_flags_o) |=> ($stable(snap_pc) && $stable(snap_data)));

  // R8
  mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_cnt != '0 && err_flags_o == 3'b000) |=> (err_flags_o == 3'b000));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && !pwrite_i && paddr_i > 8'h10) |-> (prdata_o == 32'h0));
endmodule

bind lockstep_chk lockstep_chk_sva #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .a_wr_en_i(a_wr_en_i), .b_wr_en_i(b_wr_en_i),
  .psel_i(psel_i), .penable_i(penable_i), .pwrite_i(pwrite_i),
  .paddr_i(paddr_i), .pwdata_i(pwdata_i), .prdata_o(prdata_o),
  .err_flags_o(err_flags_o), .irq_o(irq_o),
  .mask_cnt(mask_cnt), .snap_pc(snap_pc), .snap_data(snap_data)
);

// File: tb/lockstep_chk_tb.sv
module lockstep_chk_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        a_wr_en_i, b_wr_en_i;
  logic [4:0]  a_wr_idx_i, b_wr_idx_i;
  logic [31:0] a_wr_data_i, b_wr_data_i, a_rf_val_i, b_rf_val_i;
  logic        a_fetch_vld_i, b_fetch_vld_i;
  logic [31:0] a_fetch_i, b_fetch_i;
  logic        a_commit_i;
  logic [31:0] a_pc_i;
  logic        psel_i, penable_i, pwrite_i;
  logic [7:0]  paddr_i;
  logic [31:0] pwdata_i, prdata_o;
  logic        pready_o, pslverr_o, irq_o;
  logic [2:0]  err_flags_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [2:0]  m_flags;
  logic [7:0]  m_cnt;
  logic [31:0] m_pc, m_data;
  logic [4:0]  m_idx;

  always #5 clk_i = ~clk_i;

  lockstep_chk dut_i (.*);

  function automatic logic [2:0] calc_mis();
    logic [2:0] r;
    r[0] = (a_wr_en_i | b_wr_en_i) &&
           ((a_wr_en_i != b_wr_en_i) || (a_wr_idx_i != b_wr_idx_i) || (a_wr_data_i != b_wr_data_i));
    r[1] = (a_rf_val_i != b_rf_val_i);
    r[2] = (a_fetch_vld_i | b_fetch_vld_i) &&
           ((a_fetch_vld_i != b_fetch_vld_i) || (a_fetch_i != b_fetch_i));
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic idle();
    a_wr_en_i = 0; b_wr_en_i = 0; a_wr_idx_i = 0; b_wr_idx_i = 0;
    a_wr_data_i = 0; b_wr_data_i = 0; a_rf_val_i = 0; b_rf_val_i = 0;
    a_fetch_vld_i = 0; b_fetch_vld_i = 0; a_fetch_i = 0; b_fetch_i = 0;
    a_commit_i = 0; a_pc_i = 0;
  endtask

  // one clock edge plus reference model update; returns at the next falling edge
  task automatic tick();
    logic [2:0] mis;
    logic [2:0] clr;
    logic       masked;
    @(posedge clk_i);
    masked = (m_cnt != 0);
    mis = masked ? 3'b000 : calc_mis();
    clr = (psel_i && penable_i && pwrite_i && paddr_i == 8'h00) ? pwdata_i[2:0] : 3'b000;
    if (m_flags == 0 && mis == 0) begin
      if (a_commit_i) m_pc = a_pc_i;
      if (a_wr_en_i) begin m_idx = a_wr_idx_i; m_data = a_wr_data_i; end
    end
    m_flags = (m_flags & ~clr) | mis;
    if (psel_i && penable_i && pwrite_i && paddr_i == 8'h04) m_cnt = pwdata_i[7:0];
    else if (masked) m_cnt = m_cnt - 1;
    @(negedge clk_i);
  endtask

  task automatic chk_flags(input string req);
    check(req, {28'h0, irq_o, err_flags_o}, {28'h0, |m_flags, m_flags});
  endtask

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    idle();
    psel_i = 1; pwrite_i = 1; paddr_i = a; pwdata_i = d; penable_i = 0;
    tick();
    penable_i = 1;
    tick();
    psel_i = 0; penable_i = 0; pwrite_i = 0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    idle();
    psel_i = 1; pwrite_i = 0; paddr_i = a; penable_i = 0;
    tick();
    penable_i = 1;
    #1;
    d = prdata_o;
    check("R9 ready/err", {30'h0, pready_o, pslverr_o}, 32'h2);
    @(negedge clk_i);
    psel_i = 0; penable_i = 0;
    tick();
  endtask

  initial begin
    #(100000 * 10);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5eed_1234));
    idle();
    psel_i = 0; penable_i = 0; pwrite_i = 0; paddr_i = 0; pwdata_i = 0;
    m_flags = 0; m_cnt = 8'd4; m_pc = 0; m_idx = 0; m_data = 0;
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    check("R10 reset flags/irq", {28'h0, irq_o, err_flags_o}, 32'h0);
    rst_ni = 1;

    // R8: four masked edges after reset, then detection
    a_rf_val_i = 32'h1; b_rf_val_i = 32'h2;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R8 masked after reset", {29'h0, err_flags_o}, 32'h0);
    end
    tick();
    check("R2 rf mismatch after mask", {29'h0, err_flags_o}, 32'h2);
    idle();
    apb_rd(8'h04, rd); check("R8 mask count read", rd, 32'h0);
    apb_rd(8'h00, rd); check("R4 status read", rd, 32'h2);
    apb_rd(8'h08, rd); check("R10 snap pc reset", rd, 32'h0);
    apb_rd(8'h10, rd); check("R10 snap data reset", rd, 32'h0);
    apb_wr(8'h00, 32'h0); chk_flags("R4 write zero keeps flag");
    check("R5 irq held", {31'h0, irq_o}, 32'h1);
    apb_wr(8'h00, 32'h2); chk_flags("R5 irq drops after clear");

    // R6/R7 directed freeze
    a_commit_i = 1; a_pc_i = 32'h100;
    a_wr_en_i = 1; b_wr_en_i = 1; a_wr_idx_i = 3; b_wr_idx_i = 3;
    a_wr_data_i = 32'h55; b_wr_data_i = 32'h55;
    tick(); chk_flags("R1 equal writes no flag");
    idle(); a_commit_i = 1; a_pc_i = 32'h200;
    a_fetch_vld_i = 1; b_fetch_vld_i = 1; a_fetch_i = 32'hAA; b_fetch_i = 32'hAB;
    tick(); chk_flags("R3 fetch word mismatch");
    idle(); a_commit_i = 1; a_pc_i = 32'h300; a_wr_en_i = 1; b_wr_en_i = 1;
    a_wr_idx_i = 7; b_wr_idx_i = 7; a_wr_data_i = 32'h77; b_wr_data_i = 32'h77;
    tick();
    apb_rd(8'h08, rd); check("R7 pc frozen", rd, 32'h100);
    apb_rd(8'h0C, rd); check("R7 idx frozen", rd, 32'h3);
    apb_rd(8'h10, rd); check("R7 data frozen", rd, 32'h55);
    apb_wr(8'h00, 32'h7); chk_flags("R4 clear all");
    a_commit_i = 1; a_pc_i = 32'h400; tick(); idle();
    apb_rd(8'h08, rd); check("R6 pc tracks", rd, 32'h400);

    // R1/R3 variants
    a_wr_en_i = 1; b_wr_en_i = 1; a_wr_idx_i = 2; b_wr_idx_i = 4;
    tick(); chk_flags("R1 index differs"); idle();
    apb_wr(8'h00, 32'h1);
    a_wr_en_i = 1; tick(); chk_flags("R1 enable differs"); idle();
    apb_wr(8'h00, 32'h1);
    a_wr_data_i = 32'h9; b_wr_data_i = 32'h8; a_wr_idx_i = 1;
    tick(); chk_flags("R1 both disabled ignored"); idle();
    a_fetch_i = 32'h1; b_fetch_i = 32'h2;
    tick(); chk_flags("R3 both invalid ignored"); idle();
    b_fetch_vld_i = 1; tick(); chk_flags("R3 valid differs"); idle();
    apb_wr(8'h00, 32'h4); chk_flags("R5 clear fetch");

    // R8 rearm
    apb_wr(8'h04, 32'h3);
    a_rf_val_i = 32'h5;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R8 rearmed mask", {29'h0, err_flags_o}, 32'h0);
    end
    tick(); chk_flags("R8 detect after rearm"); idle();
    apb_wr(8'h00, 32'h2);

    // R9 unmapped
    apb_rd(8'h40, rd); check("R9 unmapped read", rd, 32'h0);
    apb_rd(8'h14, rd); check("R9 unmapped 0x14", rd, 32'h0);

    // random phase
    for (int it = 0; it < 600; it++) begin
      int kind;
      idle();
      a_commit_i = $urandom % 2; a_pc_i = $urandom;
      a_wr_en_i = $urandom % 2; a_wr_idx_i = 5'($urandom); a_wr_data_i = $urandom;
      a_rf_val_i = $urandom; a_fetch_vld_i = $urandom % 2; a_fetch_i = $urandom;
      b_wr_en_i = a_wr_en_i; b_wr_idx_i = a_wr_idx_i; b_wr_data_i = a_wr_data_i;
      b_rf_val_i = a_rf_val_i; b_fetch_vld_i = a_fetch_vld_i; b_fetch_i = a_fetch_i;
      kind = $urandom % 16;
      case (kind)
        0: b_wr_data_i = b_wr_data_i ^ (32'h1 << ($urandom % 32));
        1: b_wr_idx_i = b_wr_idx_i ^ 5'h1;
        2: b_wr_en_i = ~b_wr_en_i;
        3: b_rf_val_i = ~b_rf_val_i;
        4: b_fetch_i = b_fetch_i ^ 32'h80;
        5: b_fetch_vld_i = ~b_fetch_vld_i;
        default: ;
      endcase
      tick();
      chk_flags("R1 R2 R3 random compare");
      if (it % 25 == 24) begin
        apb_rd(8'h08, rd); check("R6 R7 random snap pc", rd, m_pc);
        apb_rd(8'h0C, rd); check("R6 R7 random snap idx", rd, {27'h0, m_idx});
        apb_rd(8'h10, rd); check("R6 R7 random snap data", rd, m_data);
        apb_wr(8'h00, 32'h7); chk_flags("R4 R5 random clear");
      end
    end
    report();
  end
endmodule